// File: doc/BRIEF.md
# Block Cipher I/O Sequencing Controller

This controller is the register-side front end of a 128-bit block cipher accelerator. Software writes a block as four 32-bit words and reads the result back as four 32-bit words. The controller also stores a key as two shares of eight words each and hands the cipher core their bitwise XOR. It tracks which input words have arrived and which output words have been collected. It launches the core through a start/busy/done handshake and reports idle, stall, input-ready, output-valid and output-lost status.

The block has two operation modes. In automatic mode the core is launched as soon as a complete block has been loaded. A completion that would overwrite unread output is held back, and the controller reports a stall until all four output words have been read. In manual mode a launch happens only on an explicit start trigger. A result that lands on unread output replaces it and raises a sticky lost flag. Two clear triggers wipe the input side (key shares and input words) and the output side. A configuration write made while the controller is busy is refused and raises a recoverable alert. An illegal sequencer state raises a fatal alert.

Top module: `blkio_seq`

## Requirements
- R1: `core_key` equals the bitwise XOR of share 0 and share 1, where share word k (selected by `key_share` and `key_idx`=k) sits at bits [32k+31:32k]. Both shares reset to zero.
- R2: A write with `din_we` stores `din_wdata` as input word `din_idx`. `st_in_ready` drops once all four words 0..3 have been written. While it is low, further input writes are ignored.
- R3: In automatic mode (`cfg_manual`=0), `core_start` pulses for exactly one cycle when the controller is idle, the core is not busy and all four words are loaded. `core_block` then carries word i at bits [32i+31:32i]. No trigger is needed.
- R4: In manual mode, a launch happens only in a cycle with `trig_start` while idle. In automatic mode `trig_start` has no effect.
- R5: `st_in_ready` is high again in the cycle after a launch, because the core has taken the block.
- R6: On completion with no unread output, the result is stored and `st_out_valid` rises. `dout_rdata` returns result word `dout_idx` combinationally. `st_out_valid` clears after each of the four words has been read with `dout_re`, in any order; repeated reads of one word do not clear it.
- R7: In automatic mode, a completion that meets unread output is held: `st_stall` is high and the visible output is unchanged. The held result appears once the old output has been fully read, and `st_out_lost` stays low.
- R8: In manual mode, a completion that meets unread output replaces it and sets `st_out_lost`. The flag stays set until a configuration write is accepted.
- R9: `trig_clr_in` zeroes both key shares and the input words and makes `st_in_ready` high.
- R10: `trig_clr_out` zeroes the output words and clears `st_out_valid`.
- R11: `cfg_we` while `st_idle` is low leaves mode and direction unchanged, and `alert_recov` is high for exactly the following cycle. An accepted write raises no alert.
- R12: `st_idle` is high whenever no operation is running or held. `alert_fatal` is set, and stays set, only if the sequencer state register holds an unused encoding, so it stays low in legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_manual | input | 1 | Mode to write: 1 manual, 0 automatic |
| cfg_dir | input | 1 | Direction to write (passed to the core) |
| key_we | input | 1 | Key word write strobe |
| key_share | input | 1 | Share select for the key write |
| key_idx | input | 3 | Key word index |
| key_wdata | input | 32 | Key word data |
| din_we | input | 1 | Input word write strobe |
| din_idx | input | 2 | Input word index |
| din_wdata | input | 32 | Input word data |
| dout_re | input | 1 | Output word read strobe |
| dout_idx | input | 2 | Output word index |
| dout_rdata | output | 32 | Output word selected by `dout_idx` |
| trig_start | input | 1 | Start trigger (manual mode) |
| trig_clr_in | input | 1 | Clear key shares and input words |
| trig_clr_out | input | 1 | Clear output words |
| core_start | output | 1 | Launch pulse to the cipher core |
| core_dir | output | 1 | Configured direction |
| core_key | output | 256 | Recombined key |
| core_block | output | 128 | Input block to the core |
| core_busy | input | 1 | Core is working |
| core_done | input | 1 | Core result valid for one cycle |
| core_result | input | 128 | Core result block |
| st_idle | output | 1 | No operation running or held |
| st_stall | output | 1 | Result held behind unread output |
| st_in_ready | output | 1 | Input block can be written |
| st_out_valid | output | 1 | Output block is readable |
| st_out_lost | output | 1 | Sticky: unread output was overwritten |
| alert_fatal | output | 1 | Sticky fatal alert |
| alert_recov | output | 1 | One-cycle recoverable alert |

## Verification
Several rules are checked by properties on every cycle. Launches are single-cycle pulses that occur only while idle. A trigger in automatic mode never launches a block that is not yet full. The input side stays blocked until it is consumed or cleared, and a completed read-out or an output clear drops output-valid. Any overwrite of unread output sets the lost flag, which then holds until an accepted configuration write. A refused configuration write produces the alert. Other behaviour needs whole scenarios from the bench. These include the recombined key and the result data word by word, read-out in random order, and a held result that surfaces only after the old output is drained. The bench also shows that a refused configuration really left the mode unchanged, and that the two clears wipe the data they own.

// File: rtl/blkio_pkg.sv
package blkio_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_STALL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/blkio_key_store.sv
module blkio_key_store #(
  parameter int WORD_W    = 32,
  parameter int KEY_WORDS = 8,
  localparam int KIDX_W   = $clog2(KEY_WORDS),
  localparam int KEY_W    = WORD_W * KEY_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              share,
  input  logic [KIDX_W-1:0] idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clr,
  output logic [KEY_W-1:0]  key_out
);
  function automatic logic [WORD_W-1:0] merge_shares(input logic [WORD_W-1:0] a,
                                                     input logic [WORD_W-1:0] b);
    return a ^ b;
  endfunction

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] sh0_q, sh1_q;
    logic hit;
    assign hit = we && (idx == KIDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh0_q <= '0;
        sh1_q <= '0;
      end else if (clr) begin
        sh0_q <= '0;
        sh1_q <= '0;
      end else if (hit) begin
        if (share) sh1_q <= wdata;
        else       sh0_q <= wdata;
      end
    end

    assign key_out[g*WORD_W +: WORD_W] = merge_shares(sh0_q, sh1_q);
  end
endmodule

// File: rtl/blkio_in_buf.sv
module blkio_in_buf #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  localparam int BIDX_W   = $clog2(BLK_WORDS),
  localparam int BLK_W    = WORD_W * BLK_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BIDX_W-1:0] idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clr,
  input  logic              consume,
  output logic              ready,
  output logic              full,
  output logic [BLK_W-1:0]  block
);
  logic [BLK_WORDS-1:0] mask_q, mask_d;
  logic accept;

  function automatic logic [BLK_WORDS-1:0] word_bit(input logic [BIDX_W-1:0] i);
    return BLK_WORDS'(1) << i;
  endfunction

  assign full   = &mask_q;
  assign ready  = !full;
  assign accept = we && ready && !clr;

  always_comb begin
    mask_d = consume ? '0 : mask_q;
    if (accept) mask_d = mask_d | word_bit(idx);
    if (clr)    mask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] data_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 data_q <= '0;
      else if (clr)                               data_q <= '0;
      else if (accept && idx == BIDX_W'(g))       data_q <= wdata;
    end
    assign block[g*WORD_W +: WORD_W] = data_q;
  end
endmodule

// File: rtl/blkio_out_buf.sv
module blkio_out_buf #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  localparam int BIDX_W   = $clog2(BLK_WORDS),
  localparam int BLK_W    = WORD_W * BLK_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deliver,
  input  logic [BLK_W-1:0]  ddata,
  input  logic              rd,
  input  logic [BIDX_W-1:0] ridx,
  input  logic              clr,
  input  logic              lost_clr,
  output logic [WORD_W-1:0] rdata,
  output logic              valid,
  output logic              lost,
  output logic              drained
);
  logic [BLK_WORDS-1:0] rmask_q, rmask_nx;
  logic [BLK_WORDS-1:0][WORD_W-1:0] words;
  logic valid_q, lost_q, rd_hit;

  function automatic logic [BLK_WORDS-1:0] mark_read(input logic [BLK_WORDS-1:0] m,
                                                     input logic [BIDX_W-1:0] i);
    return m | (BLK_WORDS'(1) << i);
  endfunction

  assign rd_hit   = rd && valid_q && !deliver && !clr;
  assign rmask_nx = mark_read(rmask_q, ridx);
  assign drained  = rd_hit && (&rmask_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rmask_q <= '0;
    end else if (deliver) begin
      valid_q <= 1'b1;
      rmask_q <= '0;
    end else if (clr || drained) begin
      valid_q <= 1'b0;
      rmask_q <= '0;
    end else if (rd_hit) begin
      rmask_q <= rmask_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lost_q <= 1'b0;
    else if (lost_clr)           lost_q <= 1'b0;
    else if (deliver && valid_q) lost_q <= 1'b1;
  end

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       words[g] <= '0;
      else if (deliver) words[g] <= ddata[g*WORD_W +: WORD_W];
      else if (clr)     words[g] <= '0;
    end
  end

  assign rdata = words[ridx];
  assign valid = valid_q;
  assign lost  = lost_q;
endmodule

// File: rtl/blkio_fsm.sv
module blkio_fsm
  import blkio_pkg::*;
#(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_manual,
  input  logic             cfg_dir,
  input  logic             trig_start,
  input  logic             in_full,
  input  logic             core_busy,
  input  logic             core_done,
  input  logic [BLK_W-1:0] core_result,
  input  logic             out_valid,
  output logic             launch,
  output logic             deliver,
  output logic [BLK_W-1:0] deliver_data,
  output logic             cfg_accept,
  output logic             mode_manual,
  output logic             dir,
  output logic             idle,
  output logic             stall,
  output logic             fatal,
  output logic             recov
);
  seq_state_e state_q;
  logic [BLK_W-1:0] pend_q;
  logic manual_q, dir_q, fatal_q, recov_q;
  logic hold_back;

  assign idle       = (state_q == SEQ_IDLE);
  assign stall      = (state_q == SEQ_STALL);
  assign cfg_accept = cfg_we && idle;
  assign launch     = idle && !core_busy && (manual_q ? trig_start : in_full);
  assign hold_back  = !manual_q && out_valid;
  assign deliver    = ((state_q == SEQ_RUN) && core_done && !hold_back) ||
                      (stall && !out_valid);
  assign deliver_data = stall ? pend_q : core_result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
      fatal_q <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE:  if (launch) state_q <= SEQ_RUN;
        SEQ_RUN: begin
          if (core_done) begin
            if (hold_back) begin
              pend_q  <= core_result;
              state_q <= SEQ_STALL;
            end else begin
              state_q <= SEQ_IDLE;
            end
          end
        end
        SEQ_STALL: if (!out_valid) state_q <= SEQ_IDLE;
        default: begin
          fatal_q <= 1'b1;
          state_q <= SEQ_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      manual_q <= 1'b0;
      dir_q    <= 1'b0;
      recov_q  <= 1'b0;
    end else begin
      recov_q <= cfg_we && !idle;
      if (cfg_accept) begin
        manual_q <= cfg_manual;
        dir_q    <= cfg_dir;
      end
    end
  end

  assign mode_manual = manual_q;
  assign dir         = dir_q;
  assign fatal       = fatal_q;
  assign recov       = recov_q;
endmodule

// File: rtl/blkio_seq.sv
module blkio_seq #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  parameter int KEY_WORDS = 8,
  localparam int BIDX_W   = $clog2(BLK_WORDS),
  localparam int KIDX_W   = $clog2(KEY_WORDS),
  localparam int BLK_W    = WORD_W * BLK_WORDS,
  localparam int KEY_W    = WORD_W * KEY_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_manual,
  input  logic              cfg_dir,
  input  logic              key_we,
  input  logic              key_share,
  input  logic [KIDX_W-1:0] key_idx,
  input  logic [WORD_W-1:0] key_wdata,
  input  logic              din_we,
  input  logic [BIDX_W-1:0] din_idx,
  input  logic [WORD_W-1:0] din_wdata,
  input  logic              dout_re,
  input  logic [BIDX_W-1:0] dout_idx,
  output logic [WORD_W-1:0] dout_rdata,
  input  logic              trig_start,
  input  logic              trig_clr_in,
  input  logic              trig_clr_out,
  output logic              core_start,
  output logic              core_dir,
  output logic [KEY_W-1:0]  core_key,
  output logic [BLK_W-1:0]  core_block,
  input  logic              core_busy,
  input  logic              core_done,
  input  logic [BLK_W-1:0]  core_result,
  output logic              st_idle,
  output logic              st_stall,
  output logic              st_in_ready,
  output logic              st_out_valid,
  output logic              st_out_lost,
  output logic              alert_fatal,
  output logic              alert_recov
);
  logic in_full, deliver, cfg_accept, mode_manual, out_drained;
  logic [BLK_W-1:0] deliver_data;

  blkio_key_store #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS)) u_key (
    .clk(clk), .rst_n(rst_n), .we(key_we), .share(key_share), .idx(key_idx),
    .wdata(key_wdata), .clr(trig_clr_in), .key_out(core_key)
  );

  blkio_in_buf #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_in (
    .clk(clk), .rst_n(rst_n), .we(din_we), .idx(din_idx), .wdata(din_wdata),
    .clr(trig_clr_in), .consume(core_start), .ready(st_in_ready),
    .full(in_full), .block(core_block)
  );

  blkio_fsm #(.BLK_W(BLK_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_manual(cfg_manual),
    .cfg_dir(cfg_dir), .trig_start(trig_start), .in_full(in_full),
    .core_busy(core_busy), .core_done(core_done), .core_result(core_result),
    .out_valid(st_out_valid), .launch(core_start), .deliver(deliver),
    .deliver_data(deliver_data), .cfg_accept(cfg_accept),
    .mode_manual(mode_manual), .dir(core_dir), .idle(st_idle),
    .stall(st_stall), .fatal(alert_fatal), .recov(alert_recov)
  );

  blkio_out_buf #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_out (
    .clk(clk), .rst_n(rst_n), .deliver(deliver), .ddata(deliver_data),
    .rd(dout_re), .ridx(dout_idx), .clr(trig_clr_out), .lost_clr(cfg_accept),
    .rdata(dout_rdata), .valid(st_out_valid), .lost(st_out_lost),
    .drained(out_drained)
  );
endmodule

// File: rtl/blkio_seq_chk.sv
module blkio_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic trig_clr_in,
  input logic trig_clr_out,
  input logic core_start,
  input logic st_idle,
  input logic st_stall,
  input logic st_in_ready,
  input logic st_out_valid,
  input logic st_out_lost,
  input logic alert_fatal,
  input logic alert_recov,
  input logic in_full,
  input logic deliver,
  input logic cfg_accept,
  input logic mode_manual,
  input logic out_drained
);
  p_launch_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> st_idle);
  p_launch_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  p_auto_trigger_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && !mode_manual && !in_full) |-> !core_start);
  p_consumed_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> st_in_ready);
  p_blocked_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_in_ready && !core_start && !trig_clr_in) |=> !st_in_ready);
  p_drain_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_drained |=> !st_out_valid);
  p_stall_auto_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_stall) |-> (st_out_valid && !mode_manual));
  p_overwrite_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && st_out_valid) |=> st_out_lost);
  p_lost_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_out_lost && !cfg_accept) |=> st_out_lost);
  p_clear_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_clr_out && !deliver) |=> !st_out_valid);
  p_reject_alert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !st_idle) |=> alert_recov);
  p_accept_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && st_idle) |=> !alert_recov);
  p_no_fatal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_fatal);
endmodule

bind blkio_seq blkio_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .trig_clr_in(trig_clr_in),
  .trig_clr_out(trig_clr_out), .core_start(core_start), .st_idle(st_idle),
  .st_stall(st_stall), .st_in_ready(st_in_ready), .st_out_valid(st_out_valid),
  .st_out_lost(st_out_lost), .alert_fatal(alert_fatal), .alert_recov(alert_recov),
  .in_full(in_full), .deliver(deliver), .cfg_accept(cfg_accept),
  .mode_manual(mode_manual), .out_drained(out_drained)
);

// File: tb/blkio_seq_bench.sv
module blkio_seq_bench;
  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_manual = 0, cfg_dir = 0;
  logic key_we = 0, key_share = 0;
  logic [2:0] key_idx = '0;
  logic [31:0] key_wdata = '0;
  logic din_we = 0;
  logic [1:0] din_idx = '0;
  logic [31:0] din_wdata = '0;
  logic dout_re = 0;
  logic [1:0] dout_idx = '0;
  logic [31:0] dout_rdata;
  logic trig_start = 0, trig_clr_in = 0, trig_clr_out = 0;
  logic core_start, core_dir;
  logic [255:0] core_key;
  logic [127:0] core_block;
  logic core_busy = 0, core_done = 0;
  logic [127:0] core_result = '0;
  logic st_idle, st_stall, st_in_ready, st_out_valid, st_out_lost;
  logic alert_fatal, alert_recov;

  always #2 clk = ~clk;

  blkio_seq u_blkio_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_manual(cfg_manual),
    .cfg_dir(cfg_dir), .key_we(key_we), .key_share(key_share), .key_idx(key_idx),
    .key_wdata(key_wdata), .din_we(din_we), .din_idx(din_idx),
    .din_wdata(din_wdata), .dout_re(dout_re), .dout_idx(dout_idx),
    .dout_rdata(dout_rdata), .trig_start(trig_start), .trig_clr_in(trig_clr_in),
    .trig_clr_out(trig_clr_out), .core_start(core_start), .core_dir(core_dir),
    .core_key(core_key), .core_block(core_block), .core_busy(core_busy),
    .core_done(core_done), .core_result(core_result), .st_idle(st_idle),
    .st_stall(st_stall), .st_in_ready(st_in_ready), .st_out_valid(st_out_valid),
    .st_out_lost(st_out_lost), .alert_fatal(alert_fatal), .alert_recov(alert_recov)
  );

  // Core stand-in: fixed latency, result = block XOR both key halves.
  int cnt = 0;
  int nstart = 0;
  always @(posedge clk) begin
    core_done <= 1'b0;
    if (core_start) begin
      core_result <= core_block ^ core_key[127:0] ^ core_key[255:128];
      cnt <= LAT;
      core_busy <= 1'b1;
      nstart <= nstart + 1;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        core_done <= 1'b1;
        core_busy <= 1'b0;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] s0 [8];
  logic [31:0] s1 [8];

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(input int i, input logic [31:0] w);
    logic [31:0] k;
    k = 32'h0;
    for (int h = 0; h < 2; h++) k = k ^ s0[i + 4*h] ^ s1[i + 4*h];
    return w ^ k;
  endfunction

  function automatic logic [255:0] ref_key();
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = s0[k] ^ s1[k];
    return r;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_key(input bit sh, input int k, input logic [31:0] d);
    key_we = 1; key_share = sh; key_idx = 3'(k); key_wdata = d;
    cyc(1);
    key_we = 0;
    if (sh) s1[k] = d; else s0[k] = d;
  endtask

  task automatic put_word(input int i, input logic [31:0] d);
    din_we = 1; din_idx = 2'(i); din_wdata = d;
    cyc(1);
    din_we = 0;
  endtask

  task automatic get_word(input int i, input bit consume, output logic [31:0] d);
    dout_idx = 2'(i); dout_re = consume;
    #1 d = dout_rdata;
    cyc(1);
    dout_re = 0;
  endtask

  task automatic set_cfg(input bit man);
    cfg_we = 1; cfg_manual = man; cfg_dir = 0;
    cyc(1);
    cfg_we = 0;
  endtask

  task automatic pulse_start(); trig_start = 1; cyc(1); trig_start = 0; endtask

  task automatic wait_valid();
    for (int t = 0; t < 40 && !st_out_valid; t++) cyc(1);
  endtask

  task automatic load_block(input logic [31:0] b [4]);
    for (int i = 0; i < 4; i++) put_word(i, b[i]);
  endtask

  task automatic check_out(input logic [31:0] b [4], input string tag);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      get_word(i, 0, d);
      chk(d === ref_word(i, b[i]), tag, 256'(d), 256'(ref_word(i, b[i])));
    end
  endtask

  task automatic drain();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) get_word(i, 1, d);
    cyc(1);
  endtask

  task automatic rand_block(output logic [31:0] b [4]);
    for (int i = 0; i < 4; i++) b[i] = $urandom;
  endtask

  initial begin
    logic [31:0] a [4];
    logic [31:0] b [4];
    logic [31:0] d;
    logic [127:0] exp_blk;
    int ord [4];
    int n0;
    void'($urandom(32'd1357));
    for (int k = 0; k < 8; k++) begin s0[k] = '0; s1[k] = '0; end
    cyc(3);
    rst_n = 1;
    cyc(1);
    // Reset state
    chk(st_idle && st_in_ready && !st_out_valid && !st_stall && !st_out_lost,
        "R12 reset status", 256'({st_idle, st_in_ready, st_out_valid, st_stall, st_out_lost}),
        256'(5'b11000));
    chk(core_key === '0, "R1 reset key", core_key, 256'h0);
    chk(!alert_fatal && !alert_recov, "R12 reset alerts",
        256'({alert_fatal, alert_recov}), 256'h0);

    for (int k = 0; k < 8; k++) begin
      put_key(0, k, $urandom);
      put_key(1, k, $urandom);
    end
    chk(core_key === ref_key(), "R1 key recombine", core_key, ref_key());
    set_cfg(0);

    // Random automatic-mode blocks, words loaded and read in shuffled order
    for (int it = 0; it < 10; it++) begin
      rand_block(a);
      for (int i = 0; i < 4; i++) ord[i] = i;
      for (int i = 3; i > 0; i--) begin
        int j, t;
        j = int'($urandom_range(i, 0)); t = ord[i]; ord[i] = ord[j]; ord[j] = t;
      end
      for (int i = 0; i < 4; i++) put_word(ord[i], a[ord[i]]);
      exp_blk = {a[3], a[2], a[1], a[0]};
      chk(!st_in_ready, "R2 ready low when full", 256'(st_in_ready), 256'h0);
      chk(core_start && core_block === exp_blk, "R3 auto launch",
          256'({core_start, core_block}), 256'({1'b1, exp_blk}));
      cyc(1);
      chk(st_in_ready && !core_start, "R5 ready after consume",
          256'({st_in_ready, core_start}), 256'(2'b10));
      wait_valid();
      chk(st_out_valid, "R6 output valid", 256'(st_out_valid), 256'h1);
      get_word(ord[0], 1, d);
      get_word(ord[0], 1, d);
      for (int i = 1; i < 4; i++) begin
        chk(st_out_valid, "R6 valid until all read", 256'(st_out_valid), 256'h1);
        get_word(ord[i], 1, d);
        chk(d === ref_word(ord[i], a[ord[i]]), "R6 result word", 256'(d),
            256'(ref_word(ord[i], a[ord[i]])));
      end
      chk(!st_out_valid && !st_out_lost, "R6 cleared after read-out",
          256'({st_out_valid, st_out_lost}), 256'h0);
    end

    // Stall: second result held while first unread
    rand_block(a); rand_block(b);
    load_block(a); wait_valid();
    load_block(b); cyc(15);
    chk(st_stall && !st_idle, "R7 stall raised", 256'({st_stall, st_idle}), 256'(2'b10));
    check_out(a, "R7 output kept during stall");
    chk(st_in_ready, "R5 ready while stalled", 256'(st_in_ready), 256'h1);
    drain();
    wait_valid();
    chk(st_out_valid && !st_stall && !st_out_lost && st_idle, "R7 held result delivered",
        256'({st_out_valid, st_stall, st_out_lost, st_idle}), 256'(4'b1001));
    check_out(b, "R7 held result data");
    drain();

    // Start trigger ignored in automatic mode
    n0 = nstart;
    rand_block(a);
    put_word(0, a[0]); put_word(1, a[1]);
    pulse_start(); cyc(12);
    chk(nstart == n0 && !st_out_valid, "R4 auto ignores trigger",
        256'(nstart - n0), 256'h0);
    put_word(2, a[2]); put_word(3, a[3]);
    wait_valid(); check_out(a, "R3 partial then full"); drain();

    // Manual mode
    set_cfg(1);
    n0 = nstart;
    rand_block(a);
    load_block(a);
    put_word(0, ~a[0]);
    cyc(10);
    chk(nstart == n0 && !st_in_ready && st_idle, "R4 manual waits for trigger",
        256'(nstart - n0), 256'h0);
    pulse_start(); wait_valid();
    check_out(a, "R2 write while full ignored");
    rand_block(b); load_block(b); pulse_start(); cyc(15);
    chk(st_out_lost && st_out_valid, "R8 overwrite sets lost",
        256'({st_out_lost, st_out_valid}), 256'(2'b11));
    check_out(b, "R8 new data replaces");

    // Refused configuration while running
    rand_block(a); load_block(a); pulse_start();
    chk(!st_idle, "R12 busy not idle", 256'(st_idle), 256'h0);
    cfg_we = 1; cfg_manual = 0; cyc(1); cfg_we = 0;
    chk(alert_recov, "R11 refused write alert", 256'(alert_recov), 256'h1);
    cyc(1);
    chk(!alert_recov, "R11 alert one cycle", 256'(alert_recov), 256'h0);
    cyc(12);
    chk(st_out_lost, "R8 lost still set", 256'(st_out_lost), 256'h1);
    n0 = nstart;
    rand_block(b); load_block(b); cyc(10);
    chk(nstart == n0, "R11 mode unchanged (still manual)", 256'(nstart - n0), 256'h0);
    pulse_start(); cyc(12);
    set_cfg(1);
    chk(!st_out_lost && !alert_recov, "R8 lost cleared by accepted cfg",
        256'({st_out_lost, alert_recov}), 256'h0);

    // Clear input side
    put_word(0, 32'hdead_beef); put_word(1, 32'h1234_5678);
    trig_clr_in = 1; cyc(1); trig_clr_in = 0;
    for (int k = 0; k < 8; k++) begin s0[k] = '0; s1[k] = '0; end
    chk(core_key === '0 && st_in_ready, "R9 clear input", core_key, 256'h0);
    pulse_start(); cyc(12);
    for (int i = 0; i < 4; i++) a[i] = '0;
    check_out(a, "R9 cleared block and key give zero");
    drain();

    // Clear output side
    for (int k = 0; k < 8; k++) put_key(k % 2, k, $urandom);
    rand_block(a); load_block(a); pulse_start(); wait_valid();
    check_out(a, "R1 result after new key");
    trig_clr_out = 1; cyc(1); trig_clr_out = 0;
    chk(!st_out_valid, "R10 clear drops valid", 256'(st_out_valid), 256'h0);
    for (int i = 0; i < 4; i++) begin
      get_word(i, 0, d);
      chk(d === 32'h0, "R10 output zeroed", 256'(d), 256'h0);
    end
    chk(!alert_fatal && st_idle, "R12 no fatal, idle at end",
        256'({alert_fatal, st_idle}), 256'(2'b01));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule